// File: doc/BRIEF.md
# Accumulator Datapath ALU with Operand Selection

This block is the arithmetic and logic unit of a small accumulator-style microcontroller core. It works on 8 bits. Its inputs are the working register, a value read from the register file, an instruction literal, a bit-number field and the current carry flag. Two select inputs pick the two operands from these sources and a few constants. A one-hot mask built from the bit-number field is one of the operand A sources, and an invert input lets bit-clear instructions use the complement of that mask.

A 4-bit function code picks the operation. The set covers add, subtract, the bitwise operations, complement, rotate through carry, nibble swap and an unsigned multiply. The instruction decoder uses the constant one on operand B to form increment and decrement, and uses the constant zero with OR to move a value through the ALU unchanged. The outputs are the result, a zero flag and a carry-out. A parameter sets whether these outputs leave through a register stage or come straight from the combinational logic.

Top module: `acc_alu`

## Requirements
- R1: Function code 0000 adds A and B. The result is the low 8 bits of the sum, and carry-out is the ninth bit of the sum.
- R2: Function code 1000 computes A minus B modulo 256. Carry-out is 1 exactly when A is greater than or equal to B, so it is 1 when no borrow occurs.
- R3: Function codes 0001, 0010 and 0011 return A AND B, A OR B and A XOR B. Function code 0100 returns the one's complement of A. Carry-out is 0 for all four.
- R4: Function code 0101 rotates A right by one place. The carry-in goes into bit 7 and old bit 0 leaves as carry-out. Function code 0110 rotates A left by one place. The carry-in goes into bit 0 and old bit 7 leaves as carry-out.
- R5: Function code 0111 returns the low 8 bits of the unsigned product A*B. Carry-out is 1 exactly when the upper 8 bits of the product are nonzero.
- R6: Function code 1111 swaps the two 4-bit halves of A. Carry-out is 0.
- R7: Operand A select 00 picks the working register, 01 the file value, 10 the literal and 11 the bit mask.
- R8: Operand B select 00 picks the working register, 01 the file value, 10 the constant 0 and 11 the constant 1.
- R9: The bit mask has only bit number `bit_idx` set. When `mask_inv` is 1, every mask bit is inverted. `mask_inv` has no effect unless operand A select is 11.
- R10: The zero flag is 1 exactly when the 8-bit result is all zeros. This holds for every function code.
- R11: Function codes 1001 through 1110 give result 0 and carry-out 0.
- R12: With REG_OUT=1, the outputs show the result of the inputs one rising clock edge after those inputs were applied, and an active-low reset clears all outputs to 0. With REG_OUT=0, the outputs follow the inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| w_val | input | 8 | Working register value |
| file_val | input | 8 | Register-file read value |
| lit_val | input | 8 | Instruction literal |
| bit_idx | input | 3 | Bit number for the one-hot mask |
| carry_in | input | 1 | Current carry flag, used by the rotates |
| sel_a | input | 2 | Operand A source select |
| sel_b | input | 2 | Operand B source select |
| func | input | 4 | Function code |
| mask_inv | input | 1 | Inverts the bit mask |
| result | output | 8 | ALU result |
| zero | output | 1 | Result-is-zero flag |
| carry_out | output | 1 | Carry, inverted borrow, rotated-out bit or multiply overflow |

## Verification
The bench builds two copies of the block with DATA_W=8. One copy has REG_OUT=1 and the other has REG_OUT=0, and both see the same stimulus. The combinational copy is checked in the same cycle the inputs are applied. The registered copy is checked twice: just before the next edge, when it must still show the previous operation, and again after that edge. This covers both output-stage variants and the one-cycle latency. Directed cases cover carry and borrow edges, a multiply that overflows to zero, rotation of the carry in both directions, and the inverted and uninverted masks. Random operations then mix every select and function code.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [3:0] {
      FN_ADD  = 4'b0000,
      FN_AND  = 4'b0001,
      FN_OR   = 4'b0010,
      FN_XOR  = 4'b0011,
      FN_NOT  = 4'b0100,
      FN_RRC  = 4'b0101,
      FN_RLC  = 4'b0110,
      FN_MUL  = 4'b0111,
      FN_SUB  = 4'b1000,
      FN_SWAP = 4'b1111
   } alu_fn_e;

   typedef enum logic [1:0] {
      SA_WREG = 2'b00,
      SA_FILE = 2'b01,
      SA_LIT  = 2'b10,
      SA_MASK = 2'b11
   } src_a_e;

   typedef enum logic [1:0] {
      SB_WREG = 2'b00,
      SB_FILE = 2'b01,
      SB_ZERO = 2'b10,
      SB_ONE  = 2'b11
   } src_b_e;

endpackage

// File: rtl/acc_alu_opsel.sv
module acc_alu_opsel
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int IDX_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] w_val,
   input  logic [DATA_W-1:0] file_val,
   input  logic [DATA_W-1:0] lit_val,
   input  logic [IDX_W-1:0]  bit_idx,
   input  logic              mask_inv,
   input  logic [1:0]        sel_a,
   input  logic [1:0]        sel_b,
   output logic [DATA_W-1:0] opnd_a,
   output logic [DATA_W-1:0] opnd_b
);

   logic [DATA_W-1:0] mask;

   for (genvar g = 0; g < DATA_W; g++) begin : g_mask
      assign mask[g] = (bit_idx == IDX_W'(g)) ^ mask_inv;
   end

   always_comb begin
      case (src_a_e'(sel_a))
         SA_WREG: opnd_a = w_val;
         SA_FILE: opnd_a = file_val;
         SA_LIT:  opnd_a = lit_val;
         default: opnd_a = mask;
      endcase
   end

   always_comb begin
      case (src_b_e'(sel_b))
         SB_WREG: opnd_b = w_val;
         SB_FILE: opnd_b = file_val;
         SB_ZERO: opnd_b = '0;
         default: opnd_b = DATA_W'(1);
      endcase
   end

endmodule

// File: rtl/acc_alu_fn.sv
module acc_alu_fn
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic              carry_in,
   input  logic [3:0]        func,
   output logic [DATA_W-1:0] res,
   output logic              res_zero,
   output logic              res_carry
);

   localparam int HALF = DATA_W / 2;

   logic [DATA_W:0]     sum_x;
   logic [DATA_W:0]     dif_x;
   logic [2*DATA_W-1:0] prod;

   assign sum_x = {1'b0, opnd_a} + {1'b0, opnd_b};
   assign dif_x = {1'b0, opnd_a} - {1'b0, opnd_b};
   assign prod  = {{DATA_W{1'b0}}, opnd_a} * {{DATA_W{1'b0}}, opnd_b};

   always_comb begin
      res       = '0;
      res_carry = 1'b0;
      case (func)
         FN_ADD: begin
            res       = sum_x[DATA_W-1:0];
            res_carry = sum_x[DATA_W];
         end
         FN_SUB: begin
            res       = dif_x[DATA_W-1:0];
            res_carry = ~dif_x[DATA_W];
         end
         FN_AND:  res = opnd_a & opnd_b;
         FN_OR:   res = opnd_a | opnd_b;
         FN_XOR:  res = opnd_a ^ opnd_b;
         FN_NOT:  res = ~opnd_a;
         FN_RRC: begin
            res       = {carry_in, opnd_a[DATA_W-1:1]};
            res_carry = opnd_a[0];
         end
         FN_RLC: begin
            res       = {opnd_a[DATA_W-2:0], carry_in};
            res_carry = opnd_a[DATA_W-1];
         end
         FN_MUL: begin
            res       = prod[DATA_W-1:0];
            res_carry = |prod[2*DATA_W-1:DATA_W];
         end
         FN_SWAP: res = {opnd_a[HALF-1:0], opnd_a[DATA_W-1:HALF]};
         default: begin
            res       = '0;
            res_carry = 1'b0;
         end
      endcase
   end

   assign res_zero = ~|res;

endmodule

// File: rtl/acc_alu_stage.sv
module acc_alu_stage #(
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] d_res,
   input  logic              d_zero,
   input  logic              d_carry,
   output logic [DATA_W-1:0] q_res,
   output logic              q_zero,
   output logic              q_carry
);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_res   <= '0;
            q_zero  <= 1'b0;
            q_carry <= 1'b0;
         end else begin
            q_res   <= d_res;
            q_zero  <= d_zero;
            q_carry <= d_carry;
         end
      end
   end else begin : g_pass
      assign q_res   = d_res;
      assign q_zero  = d_zero;
      assign q_carry = d_carry;
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1,
   localparam int IDX_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] w_val,
   input  logic [DATA_W-1:0] file_val,
   input  logic [DATA_W-1:0] lit_val,
   input  logic [IDX_W-1:0]  bit_idx,
   input  logic              carry_in,
   input  logic [1:0]        sel_a,
   input  logic [1:0]        sel_b,
   input  logic [3:0]        func,
   input  logic              mask_inv,
   output logic [DATA_W-1:0] result,
   output logic              zero,
   output logic              carry_out
);

   if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("acc_alu: DATA_W must be even and at least 4");
   end

   logic [DATA_W-1:0] opnd_a;
   logic [DATA_W-1:0] opnd_b;
   logic [DATA_W-1:0] fn_res;
   logic              fn_zero;
   logic              fn_carry;

   acc_alu_opsel #(.DATA_W(DATA_W), .IDX_W(IDX_W)) opsel_i (
      .w_val    (w_val),
      .file_val (file_val),
      .lit_val  (lit_val),
      .bit_idx  (bit_idx),
      .mask_inv (mask_inv),
      .sel_a    (sel_a),
      .sel_b    (sel_b),
      .opnd_a   (opnd_a),
      .opnd_b   (opnd_b)
   );

   acc_alu_fn #(.DATA_W(DATA_W)) fn_i (
      .opnd_a    (opnd_a),
      .opnd_b    (opnd_b),
      .carry_in  (carry_in),
      .func      (func),
      .res       (fn_res),
      .res_zero  (fn_zero),
      .res_carry (fn_carry)
   );

   acc_alu_stage #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) stage_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_res   (fn_res),
      .d_zero  (fn_zero),
      .d_carry (fn_carry),
      .q_res   (result),
      .q_zero  (zero),
      .q_carry (carry_out)
   );

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1,
   parameter int IDX_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] w_val,
   input logic [DATA_W-1:0] file_val,
   input logic [IDX_W-1:0]  bit_idx,
   input logic [1:0]        sel_a,
   input logic [1:0]        sel_b,
   input logic [3:0]        func,
   input logic              mask_inv,
   input logic [DATA_W-1:0] result,
   input logic              zero,
   input logic              carry_out
);

   localparam int HALF = DATA_W / 2;

   logic              vld;
   logic [DATA_W-1:0] c_w;
   logic [DATA_W-1:0] c_f;
   logic [IDX_W-1:0]  c_idx;
   logic [1:0]        c_sa;
   logic [1:0]        c_sb;
   logic [3:0]        c_fn;
   logic              c_inv;

   if (REG_OUT) begin : g_delay
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld   <= 1'b0;
            c_w   <= '0;
            c_f   <= '0;
            c_idx <= '0;
            c_sa  <= '0;
            c_sb  <= '0;
            c_fn  <= '0;
            c_inv <= 1'b0;
         end else begin
            vld   <= 1'b1;
            c_w   <= w_val;
            c_f   <= file_val;
            c_idx <= bit_idx;
            c_sa  <= sel_a;
            c_sb  <= sel_b;
            c_fn  <= func;
            c_inv <= mask_inv;
         end
      end
   end else begin : g_direct
      assign vld   = rst_n;
      assign c_w   = w_val;
      assign c_f   = file_val;
      assign c_idx = bit_idx;
      assign c_sa  = sel_a;
      assign c_sb  = sel_b;
      assign c_fn  = func;
      assign c_inv = mask_inv;
   end

   // R10
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld |-> (zero == (result == '0)));

   // R1
   incr_file_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && c_fn == 4'b0000 && c_sa == 2'b01 && c_sb == 2'b11)
      |-> ({carry_out, result} == ({1'b0, c_f} + (DATA_W+1)'(1))));

   // R3
   logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && (c_fn == 4'b0001 || c_fn == 4'b0010 || c_fn == 4'b0011 || c_fn == 4'b0100))
      |-> !carry_out);

   // R3
   compl_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && c_fn == 4'b0100 && c_sa == 2'b00) |-> (result == ~c_w));

   // R6
   swap_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && c_fn == 4'b1111 && c_sa == 2'b00)
      |-> (result == {c_w[HALF-1:0], c_w[DATA_W-1:HALF]} && !carry_out));

   // R9
   bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && c_fn == 4'b0010 && c_sa == 2'b11 && c_sb == 2'b10 && !c_inv)
      |-> ($onehot0(result) && result[c_idx]));

   // R11
   unused_fn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && c_fn >= 4'b1001 && c_fn <= 4'b1110) |-> (result == '0 && !carry_out));

endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT), .IDX_W(IDX_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .w_val     (w_val),
   .file_val  (file_val),
   .bit_idx   (bit_idx),
   .sel_a     (sel_a),
   .sel_b     (sel_b),
   .func      (func),
   .mask_inv  (mask_inv),
   .result    (result),
   .zero      (zero),
   .carry_out (carry_out)
);

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] w_val = 8'h3C;
   logic [7:0] file_val = 8'hC3;
   logic [7:0] lit_val = 8'h77;
   logic [2:0] bit_idx = 3'd5;
   logic       carry_in = 1'b1;
   logic [1:0] sel_a = 2'b00;
   logic [1:0] sel_b = 2'b00;
   logic [3:0] func = 4'b0000;
   logic       mask_inv = 1'b0;

   logic [7:0] r_res, c_res;
   logic       r_z, c_z, r_c, c_c;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   int exp_res, exp_c, exp_z;
   int prv_res, prv_c, prv_z;
   bit prv_ok = 1'b0;

   always #5 clk = ~clk;

   acc_alu #(.DATA_W(8), .REG_OUT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .w_val(w_val), .file_val(file_val), .lit_val(lit_val),
      .bit_idx(bit_idx), .carry_in(carry_in), .sel_a(sel_a), .sel_b(sel_b), .func(func),
      .mask_inv(mask_inv), .result(r_res), .zero(r_z), .carry_out(r_c)
   );

   acc_alu #(.DATA_W(8), .REG_OUT(1'b0)) comb_i (
      .clk(clk), .rst_n(rst_n), .w_val(w_val), .file_val(file_val), .lit_val(lit_val),
      .bit_idx(bit_idx), .carry_in(carry_in), .sel_a(sel_a), .sel_b(sel_b), .func(func),
      .mask_inv(mask_inv), .result(c_res), .zero(c_z), .carry_out(c_c)
   );

   task automatic check(string tag, string what, int act, int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   function automatic string tag_of(int f);
      case (f)
         0: return "R1";
         8: return "R2";
         1, 2, 3, 4: return "R3";
         5, 6: return "R4";
         7: return "R5";
         15: return "R6";
         default: return "R11";
      endcase
   endfunction

   task automatic model();
      int a, b, p;
      case (sel_a)
         2'b00: a = int'(w_val);
         2'b01: a = int'(file_val);
         2'b10: a = int'(lit_val);
         default: begin
            a = 1 << bit_idx;
            if (mask_inv) a = (~a) & 255;
         end
      endcase
      case (sel_b)
         2'b00: b = int'(w_val);
         2'b01: b = int'(file_val);
         2'b10: b = 0;
         default: b = 1;
      endcase
      exp_c = 0;
      case (int'(func))
         0: begin p = a + b; exp_res = p & 255; exp_c = p >> 8; end
         8: begin exp_res = (a - b) & 255; exp_c = (a >= b) ? 1 : 0; end
         1: exp_res = a & b;
         2: exp_res = a | b;
         3: exp_res = a ^ b;
         4: exp_res = (~a) & 255;
         5: begin exp_res = (int'(carry_in) << 7) | (a >> 1); exp_c = a & 1; end
         6: begin exp_res = ((a << 1) & 255) | int'(carry_in); exp_c = a >> 7; end
         7: begin p = a * b; exp_res = p & 255; exp_c = (p > 255) ? 1 : 0; end
         15: exp_res = ((a & 15) << 4) | (a >> 4);
         default: exp_res = 0;
      endcase
      exp_z = (exp_res == 0) ? 1 : 0;
   endtask

   // Apply inputs at a falling edge, check the combinational copy at once,
   // the registered copy just before and just after the next rising edge.
   task automatic step(string tag, logic [3:0] f, logic [1:0] sa, logic [1:0] sb,
                       logic [7:0] w, logic [7:0] fv, logic [7:0] lv,
                       logic [2:0] idx, logic ci, logic inv);
      @(negedge clk);
      func = f; sel_a = sa; sel_b = sb; w_val = w; file_val = fv; lit_val = lv;
      bit_idx = idx; carry_in = ci; mask_inv = inv;
      model();
      #1;
      check(tag, "comb result", int'(c_res), exp_res);
      check(tag, "comb carry", int'(c_c), exp_c);
      check("R10", "comb zero", int'(c_z), exp_z);
      if (prv_ok) check("R12", "reg result held", int'(r_res), prv_res);
      @(posedge clk);
      #1;
      check(tag, "reg result", int'(r_res), exp_res);
      check(tag, "reg carry", int'(r_c), exp_c);
      check("R10", "reg zero", int'(r_z), exp_z);
      prv_res = exp_res; prv_c = exp_c; prv_z = exp_z; prv_ok = 1'b1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R12", "reset result", int'(r_res), 0);
      check("R12", "reset zero", int'(r_z), 0);
      check("R12", "reset carry", int'(r_c), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 add overflow to zero, plain add
      step("R1", 4'h0, 2'b00, 2'b11, 8'hFF, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0);
      step("R1", 4'h0, 2'b01, 2'b00, 8'h21, 8'h34, 8'h00, 3'd0, 1'b1, 1'b0);
      // R2 equal, borrow, decrement from zero
      step("R2", 4'h8, 2'b01, 2'b00, 8'h05, 8'h05, 8'h00, 3'd0, 1'b0, 1'b0);
      step("R2", 4'h8, 2'b01, 2'b00, 8'h04, 8'h03, 8'h00, 3'd0, 1'b0, 1'b0);
      step("R2", 4'h8, 2'b01, 2'b11, 8'h00, 8'h00, 8'h00, 3'd0, 1'b1, 1'b0);
      // R7 operand A sources through OR with zero
      step("R7", 4'h2, 2'b10, 2'b10, 8'h11, 8'h22, 8'h5A, 3'd0, 1'b0, 1'b0);
      step("R7", 4'h2, 2'b01, 2'b10, 8'h11, 8'h22, 8'h5A, 3'd0, 1'b0, 1'b0);
      step("R7", 4'h2, 2'b00, 2'b10, 8'h11, 8'h22, 8'h5A, 3'd0, 1'b0, 1'b0);
      // R8 operand B sources
      step("R8", 4'h3, 2'b10, 2'b00, 8'h0F, 8'hF0, 8'hFF, 3'd0, 1'b0, 1'b0);
      step("R8", 4'h3, 2'b10, 2'b01, 8'h0F, 8'hF0, 8'hFF, 3'd0, 1'b0, 1'b0);
      // R9 set, clear, test, and inv ignored when A is not the mask
      step("R9", 4'h2, 2'b11, 2'b00, 8'h00, 8'h00, 8'h00, 3'd3, 1'b0, 1'b0);
      step("R9", 4'h1, 2'b11, 2'b00, 8'hFF, 8'h00, 8'h00, 3'd3, 1'b0, 1'b1);
      step("R9", 4'h1, 2'b11, 2'b01, 8'h00, 8'h08, 8'h00, 3'd3, 1'b0, 1'b0);
      step("R9", 4'h1, 2'b11, 2'b01, 8'h00, 8'h08, 8'h00, 3'd2, 1'b0, 1'b0);
      step("R9", 4'h2, 2'b00, 2'b10, 8'h81, 8'h00, 8'h00, 3'd7, 1'b0, 1'b1);
      step("R9", 4'h2, 2'b11, 2'b10, 8'h00, 8'h00, 8'h00, 3'd7, 1'b0, 1'b0);
      // R4 rotates
      step("R4", 4'h5, 2'b00, 2'b00, 8'h01, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0);
      step("R4", 4'h5, 2'b00, 2'b00, 8'h01, 8'h00, 8'h00, 3'd0, 1'b1, 1'b0);
      step("R4", 4'h6, 2'b01, 2'b00, 8'h00, 8'h80, 8'h00, 3'd0, 1'b1, 1'b0);
      step("R4", 4'h6, 2'b01, 2'b00, 8'h00, 8'h41, 8'h00, 3'd0, 1'b0, 1'b0);
      // R5 multiply
      step("R5", 4'h7, 2'b00, 2'b01, 8'h10, 8'h10, 8'h00, 3'd0, 1'b0, 1'b0);
      step("R5", 4'h7, 2'b00, 2'b01, 8'h0F, 8'h11, 8'h00, 3'd0, 1'b0, 1'b0);
      // R6 swap, R3 complement
      step("R6", 4'hF, 2'b10, 2'b00, 8'h00, 8'h00, 8'hA5, 3'd0, 1'b1, 1'b0);
      step("R3", 4'h4, 2'b00, 2'b00, 8'hFF, 8'h00, 8'h00, 3'd0, 1'b1, 1'b0);
      // R11 unused code
      step("R11", 4'h9, 2'b00, 2'b00, 8'hFF, 8'hFF, 8'h00, 3'd0, 1'b1, 1'b0);
      step("R11", 4'hE, 2'b01, 2'b11, 8'hFF, 8'h7F, 8'h00, 3'd0, 1'b1, 1'b0);

      for (int i = 0; i < 400; i++) begin
         logic [3:0] f;
         f = 4'($urandom_range(0, 15));
         step(tag_of(int'(f)), f, 2'($urandom), 2'($urandom), 8'($urandom), 8'($urandom),
              8'($urandom), 3'($urandom), 1'($urandom), 1'($urandom));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule